// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter

This block sits between a processor bus that time-shares its low address bits with its data bits and a memory or peripheral port that expects separate address and data buses. While the address latch enable strobe (`ale`) is high, the shared lines and the dedicated upper lines carry the address. The block passes that address straight through and freezes it when the strobe falls. After that it treats the shared lines as data, and a read/write status bit captured with the address sets their direction.

Everything runs on one system clock. The strobe is sampled on every rising edge. The first clock cycle in which it reads low after reading high is the trailing edge. On that edge the block captures the address and the direction bit that were present during the last cycle the strobe was high. It then holds them until the strobe rises again. A parameter selects one of two bus shapes. The narrow shape has 8 shared lines and 8 dedicated upper lines, giving a 16-bit address. The wide shape has 16 shared lines and 4 upper lines, giving a 20-bit address. In the wide shape the 4 upper lines carry status bits during the data phase, and the block captures those bits and presents them on a separate output.

Top module: `adbus_splitter`

## Requirements
- R1: While `rst_n` is low, the held address and the captured status are zero, and `addr_valid`, `mem_rd`, `mem_wr` and `ad_oe` are all 0. An active data phase ends at once when reset is asserted.
- R2: While `ale` is high, `mem_addr` equals `{hi_in, ad_in}` in the same cycle. While `ale` is high, `mem_rd`, `mem_wr` and `ad_oe` are 0.
- R3: In the first cycle in which `ale` is low after being high, `mem_addr` shows the `{hi_in, ad_in}` value from the last clock cycle in which `ale` was high.
- R4: After the trailing edge, `mem_addr` holds the captured address while `ale` stays low, whatever the shared and upper lines do.
- R5: `addr_valid` is high for exactly one clock: the cycle after the first low cycle of `ale`.
- R6: When `s1_rd` was 1 in the last `ale`-high cycle (read), `mem_rd` and `ad_oe` are 1 from the first low cycle until `ale` rises again, `mem_wr` is 0, and `ad_out` equals `mem_rdata`.
- R7: When `s1_rd` was 0 in the last `ale`-high cycle (write), `mem_wr` is 1 from the first low cycle until `ale` rises, `mem_rd` and `ad_oe` are 0, and `mem_wdata` equals `ad_in`.
- R8: In the cycle in which `ale` goes high again, `mem_rd`, `mem_wr` and `ad_oe` drop to 0.
- R9: With `WIDE_BUS=1` the address is 20 bits. `cyc_status` takes the value of `hi_in` (the 4 status bits) at the clock edge that ends the `addr_valid` cycle, and keeps it until the next such edge. With `WIDE_BUS=0`, `cyc_status` is always 0.
- R10: Changes on `s1_rd` during a data phase do not change the direction of the data phase under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address latch enable strobe from the processor |
| s1_rd | input | 1 | Direction status bit: 1 read, 0 write |
| ad_in | input | AD_W (8 or 16) | Shared address/data lines as seen from the processor pins |
| hi_in | input | HI_W (8 or 4) | Dedicated upper address lines; status bits in the wide data phase |
| ad_out | output | AD_W | Read data to drive onto the shared lines |
| ad_oe | output | 1 | Drive enable for `ad_out` onto the shared lines |
| mem_addr | output | AD_W+HI_W | Demultiplexed address |
| addr_valid | output | 1 | One-clock pulse after each captured address |
| mem_rd | output | 1 | Read strobe for the data phase |
| mem_wr | output | 1 | Write strobe for the data phase |
| mem_wdata | output | AD_W | Write data taken from the shared lines |
| mem_rdata | input | AD_W | Read data from memory or peripheral |
| cyc_status | output | 4 | Captured status bits (wide shape only, else zero) |

## Verification
On every cycle the assertions check the following. The address after a trailing edge equals the bus value two clocks earlier. The address stays unchanged across consecutive low cycles of the strobe. The valid pulse never lasts two clocks. Exactly one strobe starts on the trailing edge. The wide status only changes after a valid pulse. Only the bench scenarios can show the rest, because it depends on values chosen outside the block and on when they were applied. This covers the same-cycle pass-through while the strobe is high, the direction staying fixed against a toggling status bit, read data and write data passing in the right direction, and reset cutting off a data phase midway.

// File: rtl/adbus_pkg.sv
`timescale 1ns/1ps
package adbus_pkg;

   localparam int NARROW_AD_W = 8;
   localparam int NARROW_HI_W = 8;
   localparam int WIDE_AD_W   = 16;
   localparam int WIDE_HI_W   = 4;
   localparam int STAT_W      = 4;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_DATA = 1'b1
   } bus_phase_e;

   function automatic int ad_width(input bit wide);
      return wide ? WIDE_AD_W : NARROW_AD_W;
   endfunction

   function automatic int hi_width(input bit wide);
      return wide ? WIDE_HI_W : NARROW_HI_W;
   endfunction

endpackage

// File: rtl/adbus_ale_edge.sv
`timescale 1ns/1ps
module adbus_ale_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ale,
   output logic ale_fall
);

   logic ale_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ale_q <= 1'b0;
      else        ale_q <= ale;
   end

   // trailing edge: strobe seen high last clock, low now
   assign ale_fall = ale_q & ~ale;

endmodule

// File: rtl/adbus_addr_hold.sv
`timescale 1ns/1ps
module adbus_addr_hold #(
   parameter int LINE_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic              ale_fall,
   input  logic [LINE_W-1:0] lines_in,
   output logic [LINE_W-1:0] lines_out
);

   if (LINE_W < 2) begin : g_bad_width
      $error("adbus_addr_hold: LINE_W must be at least 2");
   end

   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         hold_q <= '0;
      end else begin
         line_q <= lines_in;
         if (ale_fall) hold_q <= line_q;
      end
   end

   // transparent while strobe high; bypass the load on the edge cycle
   always_comb begin
      if (ale)           lines_out = lines_in;
      else if (ale_fall) lines_out = line_q;
      else               lines_out = hold_q;
   end

endmodule

// File: rtl/adbus_phase_ctrl.sv
`timescale 1ns/1ps
module adbus_phase_ctrl
   import adbus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ale,
   input  logic ale_fall,
   input  logic dir_rd,
   output logic addr_valid,
   output logic mem_rd,
   output logic mem_wr,
   output logic bus_oe
);

   bus_phase_e ph_q;
   logic       valid_q;
   logic       data_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         valid_q <= 1'b0;
      end else begin
         valid_q <= ale_fall;
         if (ale)           ph_q <= PH_IDLE;
         else if (ale_fall) ph_q <= PH_DATA;
      end
   end

   assign data_act   = ~ale & ((ph_q == PH_DATA) | ale_fall);
   assign mem_rd     = data_act &  dir_rd;
   assign mem_wr     = data_act & ~dir_rd;
   assign bus_oe     = mem_rd;
   assign addr_valid = valid_q;

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> !addr_valid);

   // R6 R7
   fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |-> (mem_rd ^ mem_wr));

endmodule

// File: rtl/adbus_splitter.sv
`timescale 1ns/1ps
module adbus_splitter
   import adbus_pkg::*;
#(
   parameter  bit WIDE_BUS = 1'b0,
   localparam int AD_W     = ad_width(WIDE_BUS),
   localparam int HI_W     = hi_width(WIDE_BUS),
   localparam int ADDR_W   = AD_W + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic              s1_rd,
   input  logic [AD_W-1:0]   ad_in,
   input  logic [HI_W-1:0]   hi_in,
   output logic [AD_W-1:0]   ad_out,
   output logic              ad_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              addr_valid,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [AD_W-1:0]   mem_wdata,
   input  logic [AD_W-1:0]   mem_rdata,
   output logic [STAT_W-1:0] cyc_status
);

   if (WIDE_BUS && (HI_W != STAT_W)) begin : g_bad_status
      $error("adbus_splitter: wide upper lines must match status width");
   end
   if (AD_W < 1 || HI_W < 1) begin : g_bad_lines
      $error("adbus_splitter: line widths must be positive");
   end

   logic              ale_fall;
   logic [ADDR_W:0]   held;

   adbus_ale_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .ale      (ale),
      .ale_fall (ale_fall)
   );

   adbus_addr_hold #(.LINE_W(ADDR_W + 1)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .ale       (ale),
      .ale_fall  (ale_fall),
      .lines_in  ({s1_rd, hi_in, ad_in}),
      .lines_out (held)
   );

   adbus_phase_ctrl u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .ale        (ale),
      .ale_fall   (ale_fall),
      .dir_rd     (held[ADDR_W]),
      .addr_valid (addr_valid),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .bus_oe     (ad_oe)
   );

   assign mem_addr  = held[ADDR_W-1:0];
   assign ad_out    = mem_rdata;
   assign mem_wdata = ad_in;

   if (WIDE_BUS) begin : g_status
      logic [STAT_W-1:0] stat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          stat_q <= '0;
         else if (addr_valid) stat_q <= hi_in[STAT_W-1:0];
      end
      assign cyc_status = stat_q;

      // R9
      status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !addr_valid |=> $stable(cyc_status));
   end else begin : g_no_status
      assign cyc_status = '0;
   end

   // R3
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !ale) |-> (mem_addr == $past({hi_in, ad_in}, 2)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ale && $past(!ale)) |-> $stable(mem_addr));

endmodule

// File: tb/test_adbus_splitter.sv
`timescale 1ns/1ps
module test_adbus_splitter;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ale = 1'b0;
   logic s1 = 1'b0;
   logic [7:0]  n_ad = '0, n_hi = '0, n_rdata = '0;
   logic [15:0] w_ad = '0, w_rdata = '0;
   logic [3:0]  w_hi = '0;

   logic [7:0]  n_ad_out, n_wdata;
   logic [15:0] n_addr;
   logic        n_oe, n_valid, n_rd, n_wr;
   logic [3:0]  n_stat;
   logic [15:0] w_ad_out, w_wdata;
   logic [19:0] w_addr;
   logic        w_oe, w_valid, w_rd, w_wr;
   logic [3:0]  w_stat;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   adbus_splitter #(.WIDE_BUS(1'b0)) i_adbus_splitter (
      .clk(clk), .rst_n(rst_n), .ale(ale), .s1_rd(s1),
      .ad_in(n_ad), .hi_in(n_hi), .ad_out(n_ad_out), .ad_oe(n_oe),
      .mem_addr(n_addr), .addr_valid(n_valid), .mem_rd(n_rd), .mem_wr(n_wr),
      .mem_wdata(n_wdata), .mem_rdata(n_rdata), .cyc_status(n_stat)
   );

   adbus_splitter #(.WIDE_BUS(1'b1)) i_adbus_splitter_wide (
      .clk(clk), .rst_n(rst_n), .ale(ale), .s1_rd(s1),
      .ad_in(w_ad), .hi_in(w_hi), .ad_out(w_ad_out), .ad_oe(w_oe),
      .mem_addr(w_addr), .addr_valid(w_valid), .mem_rd(w_rd), .mem_wr(w_wr),
      .mem_wdata(w_wdata), .mem_rdata(w_rdata), .cyc_status(w_stat)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one bus cycle: address phase, then ndata data cycles
   task automatic run_cycle(input bit rd, input logic [19:0] a, input logic [15:0] d,
                            input logic [3:0] st, input int ndata);
      @(negedge clk);
      ale = 1'b1; s1 = rd;
      n_ad = a[7:0]; n_hi = a[15:8]; w_ad = a[15:0]; w_hi = a[19:16];
      n_rdata = d[7:0]; w_rdata = d;
      #1;
      chk("R2 narrow address passes through", n_addr, a[15:0]);
      chk("R2 wide address passes through", w_addr, a);
      chk("R8 strobes off while ale high", {n_rd, n_wr, n_oe, w_rd, w_wr, w_oe}, 0);

      @(negedge clk);
      ale = 1'b0; s1 = ~rd;
      n_ad = rd ? 8'h5A : d[7:0]; w_ad = rd ? 16'hA55A : d;
      n_hi = ~a[15:8]; w_hi = st;
      #1;
      chk("R3 narrow captured address", n_addr, a[15:0]);
      chk("R3 wide captured address", w_addr, a);
      chk("R5 no pulse on edge cycle", {n_valid, w_valid}, 0);
      if (rd) begin
         chk("R6 read strobes", {n_rd, n_wr, n_oe, w_rd, w_wr, w_oe}, 6'b101101);
         chk("R6 narrow read data out", n_ad_out, d[7:0]);
         chk("R6 wide read data out", w_ad_out, d);
      end else begin
         chk("R7 write strobes", {n_rd, n_wr, n_oe, w_rd, w_wr, w_oe}, 6'b010010);
         chk("R7 narrow write data", n_wdata, d[7:0]);
         chk("R7 wide write data", w_wdata, d);
      end

      for (int i = 1; i < ndata; i++) begin
         @(negedge clk);
         n_ad = n_ad ^ 8'hFF; w_ad = w_ad ^ 16'hFFFF; n_hi = n_hi ^ 8'h3C;
         s1 = rd;
         if (i == 1) s1 = ~rd;
         if (i >= 2) w_hi = ~st;
         #1;
         chk("R4 narrow address held", n_addr, a[15:0]);
         chk("R4 wide address held", w_addr, a);
         chk("R5 valid pulse", {n_valid, w_valid}, (i == 1) ? 2'b11 : 2'b00);
         chk("R10 direction unchanged", {n_rd, n_wr, w_rd, w_wr}, rd ? 4'b1010 : 4'b0101);
         if (i >= 2) chk("R9 wide status captured", w_stat, st);
         chk("R9 narrow status zero", n_stat, 0);
      end
   endtask

   task automatic t_reset;
      #1;
      chk("R1 reset address", {n_addr, w_addr}, 0);
      chk("R1 reset strobes", {n_valid, n_rd, n_wr, n_oe, w_valid, w_rd, w_wr, w_oe}, 0);
      chk("R1 reset status", {n_stat, w_stat}, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 after release address", {n_addr, w_addr}, 0);
   endtask

   task automatic t_read;
      run_cycle(1'b1, 20'h3_1234, 16'hBEEF, 4'h9, 3);
   endtask

   task automatic t_write;
      run_cycle(1'b0, 20'hC_ABCD, 16'h4321, 4'h6, 4);
   endtask

   task automatic t_extremes;
      run_cycle(1'b1, 20'hF_FFFF, 16'h0000, 4'hF, 3);
      run_cycle(1'b0, 20'h0_0000, 16'hFFFF, 4'h0, 3);
   endtask

   task automatic t_short_back_to_back;
      run_cycle(1'b0, 20'h5_A5A5, 16'h1111, 4'h3, 2);
      run_cycle(1'b1, 20'hA_5A5A, 16'h2222, 4'hC, 2);
      // status from the last cycle is visible once ale is up again
      @(negedge clk);
      ale = 1'b1; #1;
      chk("R8 strobes drop when ale rises", {n_rd, n_oe, w_rd, w_oe}, 0);
      chk("R9 wide status after short cycle", w_stat, 4'hC);
   endtask

   task automatic t_reset_mid_phase;
      run_cycle(1'b1, 20'h7_0F0F, 16'h9999, 4'h2, 2);
      @(negedge clk);
      rst_n = 1'b0; #1;
      chk("R1 reset ends data phase", {n_rd, n_oe, w_rd, w_oe}, 0);
      chk("R1 reset clears address", {n_addr, w_addr}, 0);
      chk("R1 reset clears status", w_stat, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_read();
      t_write();
      t_extremes();
      t_short_back_to_back();
      t_reset_mid_phase();
      t_read();
      @(negedge clk);
      ale = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #500us;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule